// File: doc/BRIEF.md
# Preamble Tone Matcher

This block turns each received preamble tone into a raw channel estimate without a multiplier. Every known preamble tone is a BPSK value sent at one fixed boosted power. Dividing by that tone therefore reduces to two steps. The first is a sign flip, done by choosing between a value and its negation. The second is a scale by a single real constant, written as a signed-digit code with exactly two nonzero digits, so that it costs one shift-add or one shift-subtract.

Complex samples arrive as a valid/ready stream. Each sample carries its I and Q parts, the sign of the expected tone and a flag that marks whether the bin holds a known tone. The block streams out complex estimates with one register stage of latency. The tones of each transmit antenna are fed through independently by the surrounding logic.

Back-pressure rules are as follows. An input is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being emptied in the same cycle. While `out_valid` is high and `out_ready` is low, the output values stay frozen and no new sample is taken.

Top module: `preamble_tone_matcher`

## Requirements
- R1: After reset `out_valid` is low and `in_ready` is high.
- R2: For a known tone with `in_tone_neg` = 0, each output part equals floor((s_a·2^SHIFT_A + s_b·2^SHIFT_B)·x / 2^FRAC_BITS), where x is the input part and s_a, s_b are −1 when NEG_A, NEG_B are set and +1 otherwise.
- R3: For a known tone with `in_tone_neg` = 1, each output part equals floor(−(s_a·2^SHIFT_A + s_b·2^SHIFT_B)·x / 2^FRAC_BITS). The sign is applied before the floor.
- R4: The real and imaginary parts follow the same rule, each one independently of the other.
- R5: A sample accepted with `in_known` = 0 gives `out_re` = `out_im` = 0, and `out_valid` is still asserted for it.
- R6: Results outside [−2^(W_OUT−1), 2^(W_OUT−1)−1] are clamped to the nearer end of that range, not wrapped.
- R7: A sample accepted on an edge is presented on the outputs with `out_valid` high right after that same edge. Nothing appears before that edge.
- R8: While `out_valid` = 1 and `out_ready` = 0, `out_re` and `out_im` hold their values, `out_valid` stays high and `in_ready` is low.
- R9: Accepted samples leave in the order they were accepted. None is dropped or repeated, and with `out_ready` held high one sample per cycle gets through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_re | input | W_IN | Received real part, two's complement |
| in_im | input | W_IN | Received imaginary part, two's complement |
| in_tone_neg | input | 1 | Known tone is negative (1) or positive (0) |
| in_known | input | 1 | Bin carries a known preamble tone |
| out_valid | output | 1 | Estimate present |
| out_ready | input | 1 | Downstream takes the estimate |
| out_re | output | W_OUT | Estimate real part, two's complement |
| out_im | output | W_OUT | Estimate imaginary part, two's complement |

## Verification
The bench builds two copies of the block. The first uses the defaults: the constant 0.75 is formed as 8 − 2 over 8, so one digit is subtracted and three fraction bits are dropped. This build reaches flooring of negative fractions and the order of the sign flip relative to the floor, and nothing in it saturates. The second uses 4 + 1 with no fraction bits and a 12-bit output, a gain of 5, so full-scale inputs drive both saturation rails. The two copies share the same input stream and back-pressure, so the handshake is also covered.

// File: rtl/tone_match_pkg.sv
package tone_match_pkg;

  typedef enum logic {
    TONE_POS = 1'b0,
    TONE_NEG = 1'b1
  } tone_sign_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Internal width: room for the shifted sum, its negation and a guard bit,
  // and always wider than the output so the clamp compare is meaningful.
  function automatic int unsigned wide_width(input int unsigned w_in,
                                             input int unsigned w_out,
                                             input int unsigned sh_a,
                                             input int unsigned sh_b);
    return max_u(w_in + max_u(sh_a, sh_b) + 3, w_out + 1);
  endfunction

endpackage

// File: rtl/csd_scale.sv
module csd_scale #(
  parameter int unsigned W_IN    = 12,
  parameter int unsigned WW      = 18,
  parameter int unsigned SHIFT_A = 3,
  parameter int unsigned SHIFT_B = 1,
  parameter bit          NEG_A   = 1'b0,
  parameter bit          NEG_B   = 1'b1
) (
  input  logic signed [W_IN-1:0] x,
  output logic signed [WW-1:0]   y
);

  logic signed [WW-1:0] x_ext;
  logic signed [WW-1:0] term_a;
  logic signed [WW-1:0] term_b;
  logic signed [WW-1:0] digit_a;
  logic signed [WW-1:0] digit_b;

  assign x_ext  = {{(WW-W_IN){x[W_IN-1]}}, x};
  assign term_a = x_ext <<< SHIFT_A;
  assign term_b = x_ext <<< SHIFT_B;

  // Each digit's sign is fixed at build time: a plain wire or a negation.
  generate
    if (NEG_A) begin : g_a_neg
      assign digit_a = -term_a;
    end else begin : g_a_pos
      assign digit_a = term_a;
    end
    if (NEG_B) begin : g_b_neg
      assign digit_b = -term_b;
    end else begin : g_b_pos
      assign digit_b = term_b;
    end
  endgenerate

  assign y = digit_a + digit_b;

endmodule

// File: rtl/tone_lane.sv
module tone_lane
  import tone_match_pkg::*;
#(
  parameter int unsigned W_IN      = 12,
  parameter int unsigned W_OUT     = 12,
  parameter int unsigned WW        = 18,
  parameter int unsigned SHIFT_A   = 3,
  parameter int unsigned SHIFT_B   = 1,
  parameter bit          NEG_A     = 1'b0,
  parameter bit          NEG_B     = 1'b1,
  parameter int unsigned FRAC_BITS = 3
) (
  input  logic signed [W_IN-1:0]  x,
  input  tone_sign_e              tone,
  input  logic                    known,
  output logic signed [W_OUT-1:0] y
);

  localparam logic signed [WW-1:0] SAT_HI = {{(WW-W_OUT+1){1'b0}}, {(W_OUT-1){1'b1}}};
  localparam logic signed [WW-1:0] SAT_LO = {{(WW-W_OUT+1){1'b1}}, {(W_OUT-1){1'b0}}};

  logic signed [WW-1:0] scaled;
  logic signed [WW-1:0] negated;
  logic signed [WW-1:0] flipped;
  logic signed [WW-1:0] floored;
  logic signed [WW-1:0] clamped;

  csd_scale #(
    .W_IN   (W_IN),
    .WW     (WW),
    .SHIFT_A(SHIFT_A),
    .SHIFT_B(SHIFT_B),
    .NEG_A  (NEG_A),
    .NEG_B  (NEG_B)
  ) i_scale (
    .x(x),
    .y(scaled)
  );

  // Tone sign selects the subtractor output or the straight value.
  assign negated = '0 - scaled;
  assign flipped = (tone == TONE_NEG) ? negated : scaled;

  // Arithmetic shift floors toward minus infinity.
  assign floored = flipped >>> FRAC_BITS;

  always_comb begin
    if (floored > SAT_HI) begin
      clamped = SAT_HI;
    end else if (floored < SAT_LO) begin
      clamped = SAT_LO;
    end else begin
      clamped = floored;
    end
  end

  assign y = known ? clamped[W_OUT-1:0] : '0;

endmodule

// File: rtl/hold_stage.sv
module hold_stage #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] d,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] q
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (in_valid && in_ready) begin
      q <= d;
    end
  end

  p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(q)));

  p_accept_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));

endmodule

// File: rtl/preamble_tone_matcher.sv
module preamble_tone_matcher
  import tone_match_pkg::*;
#(
  parameter int unsigned W_IN      = 12,
  parameter int unsigned W_OUT     = 12,
  parameter int unsigned SHIFT_A   = 3,
  parameter int unsigned SHIFT_B   = 1,
  parameter bit          NEG_A     = 1'b0,
  parameter bit          NEG_B     = 1'b1,
  parameter int unsigned FRAC_BITS = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic signed [W_IN-1:0]  in_re,
  input  logic signed [W_IN-1:0]  in_im,
  input  logic                    in_tone_neg,
  input  logic                    in_known,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [W_OUT-1:0] out_re,
  output logic signed [W_OUT-1:0] out_im
);

  localparam int unsigned WW    = wide_width(W_IN, W_OUT, SHIFT_A, SHIFT_B);
  localparam int unsigned PARTS = 2;

  logic signed [W_IN-1:0]  lane_x [PARTS];
  logic signed [W_OUT-1:0] lane_y [PARTS];
  logic [PARTS*W_OUT-1:0]  stage_d;
  logic [PARTS*W_OUT-1:0]  stage_q;
  tone_sign_e              tone;

  assign lane_x[0] = in_re;
  assign lane_x[1] = in_im;
  assign tone      = in_tone_neg ? TONE_NEG : TONE_POS;

  generate
    for (genvar c = 0; c < PARTS; c++) begin : g_lane
      tone_lane #(
        .W_IN     (W_IN),
        .W_OUT    (W_OUT),
        .WW       (WW),
        .SHIFT_A  (SHIFT_A),
        .SHIFT_B  (SHIFT_B),
        .NEG_A    (NEG_A),
        .NEG_B    (NEG_B),
        .FRAC_BITS(FRAC_BITS)
      ) i_lane (
        .x    (lane_x[c]),
        .tone (tone),
        .known(in_known),
        .y    (lane_y[c])
      );
      assign stage_d[c*W_OUT +: W_OUT] = lane_y[c];
    end
  endgenerate

  hold_stage #(
    .W(PARTS*W_OUT)
  ) i_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .d        (stage_d),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .q        (stage_q)
  );

  assign out_re = stage_q[0 +: W_OUT];
  assign out_im = stage_q[W_OUT +: W_OUT];

  p_mask_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_known) |=> (out_valid && out_re == '0 && out_im == '0));

endmodule

// File: tb/test_preamble_tone_matcher.sv
module test_preamble_tone_matcher;

  localparam int W = 12;
  localparam int NVEC = 10;

  // columns: tone_neg, known, in_re, in_im, exp_re, exp_im  (gain 0.75, floor)
  localparam int TBL [NVEC][6] = '{
    '{0, 1,  100,   -40,    75,   -30},
    '{1, 1,  100,   -40,   -75,    30},
    '{0, 1,    5,    -5,     3,    -4},
    '{1, 1,    5,    -5,    -4,     3},
    '{0, 1, 2047, -2048,  1535, -1536},
    '{1, 1, 2047, -2048, -1536,  1536},
    '{0, 0,  300,   300,     0,     0},
    '{1, 0,   -7,     1,     0,     0},
    '{0, 1,    0,     1,     0,     0},
    '{0, 1,   -1,     3,    -1,     2}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_tone_neg = 1'b0;
  logic in_known = 1'b0;
  logic out_ready = 1'b1;
  logic signed [W-1:0] in_re = '0;
  logic signed [W-1:0] in_im = '0;
  logic in_ready, out_valid;
  logic signed [W-1:0] out_re, out_im;
  logic sat_in_ready, sat_out_valid;
  logic signed [W-1:0] sat_re, sat_im;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  preamble_tone_matcher i_preamble_tone_matcher (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_re(in_re), .in_im(in_im), .in_tone_neg(in_tone_neg), .in_known(in_known),
    .out_valid(out_valid), .out_ready(out_ready), .out_re(out_re), .out_im(out_im)
  );

  preamble_tone_matcher #(
    .W_IN(12), .W_OUT(12), .SHIFT_A(2), .SHIFT_B(0),
    .NEG_A(1'b0), .NEG_B(1'b0), .FRAC_BITS(0)
  ) i_preamble_tone_matcher_sat (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(sat_in_ready),
    .in_re(in_re), .in_im(in_im), .in_tone_neg(in_tone_neg), .in_known(in_known),
    .out_valid(sat_out_valid), .out_ready(out_ready), .out_re(sat_re), .out_im(sat_im)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input int neg, input int known, input int re, input int im);
    in_valid    = 1'b1;
    in_tone_neg = neg[0];
    in_known    = known[0];
    in_re       = W'(re);
    in_im       = W'(im);
  endtask

  task automatic check_row(input int i);
    string rq;
    if (TBL[i][1] == 0) rq = "R5";
    else if (TBL[i][0] == 1) rq = "R3";
    else rq = "R2";
    chk({rq, " valid R9"}, int'(out_valid), 1);
    chk({rq, " re"}, int'(out_re), TBL[i][4]);
    chk({rq, " im R4"}, int'(out_im), TBL[i][5]);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1: state held in reset and just after release
    chk("R1 valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid", int'(out_valid), 0);
    chk("R1 ready", int'(in_ready), 1);

    // Table walk, back to back, out_ready high (R9 order and rate)
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      if (i > 0) check_row(i - 1);
      drive(TBL[i][0], TBL[i][1], TBL[i][2], TBL[i][3]);
    end
    @(negedge clk);
    check_row(NVEC - 1);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R9 no repeat", int'(out_valid), 0);

    // R8: back-pressure holds output and blocks input
    out_ready = 1'b0;
    drive(0, 1, 16, 8);
    @(negedge clk);
    chk("R8 valid", int'(out_valid), 1);
    chk("R8 re", int'(out_re), 12);
    chk("R8 im", int'(out_im), 6);
    chk("R8 ready low", int'(in_ready), 0);
    drive(0, 1, -16, 0);
    @(negedge clk);
    chk("R8 held re", int'(out_re), 12);
    chk("R8 held im", int'(out_im), 6);
    chk("R8 held valid", int'(out_valid), 1);
    out_ready = 1'b1;
    #1;
    chk("R8 ready on drain", int'(in_ready), 1);
    @(negedge clk);
    chk("R9 next in order re", int'(out_re), -12);
    chk("R9 next valid", int'(out_valid), 1);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R9 single copy", int'(out_valid), 0);

    // R7 latency and R6 saturation on the gain-5 build
    drive(0, 1, 1000, -1000);
    #1;
    chk("R7 not before edge", int'(sat_out_valid), 0);
    @(negedge clk);
    chk("R7 after edge", int'(sat_out_valid), 1);
    chk("R6 high rail", int'(sat_re), 2047);
    chk("R6 low rail", int'(sat_im), -2048);
    drive(1, 1, 1000, -1000);
    @(negedge clk);
    chk("R6 R3 low rail", int'(sat_re), -2048);
    chk("R6 R3 high rail", int'(sat_im), 2047);
    drive(0, 1, 400, -409);
    @(negedge clk);
    chk("R6 in range", int'(sat_re), 2000);
    chk("R6 edge in range", int'(sat_im), -2045);
    in_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule